// File: doc/BRIEF.md
# Serial Display Write Transmitter

This block sits on the host side of a three-wire serial write link to a multiplexed dot-matrix display. It takes 8-bit bytes from a valid/ready stream and turns each one into a framed serial transfer. An active-low frame strobe (`ld_n`) goes low, eight bits go out on `sdo` least-significant bit first, and each bit is qualified by a rising edge of the shift clock `sck`. The strobe then returns high, and that rising strobe is what makes the display act on the byte. On request it also drives an active-low display reset pulse (`disp_rst_n`).

Every edge is placed by counting system-clock cycles. The minimum times are parameters in nanoseconds: clock high and low width, strobe setup, data setup and hold, the strobe-high gap between frames and the reset pulse width. They are turned into cycle counts, always rounding up. `sdo` changes on the falling edge of `sck` and the display samples it on the rising edge.

Back-pressure: a byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle with no reset pending. It drops from the cycle after acceptance until the inter-frame gap that follows the frame has fully elapsed. The upstream side may hold `in_valid` high with stable `in_data` for as long as it likes. `rst_req` is a plain one-cycle request. A request that arrives during a frame is remembered and served after that frame and its gap. A pending or present request wins over a waiting byte.

Top module: `serdisp_tx`

## Requirements
- R1: While and after `rst_n` is low, outputs rest at `ld_n`=1, `sck`=0, `disp_rst_n`=1, and `in_ready`=1 once idle.
- R2: A byte is accepted only when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is low from the cycle after acceptance until at least GAP_NS of `ld_n` high has followed the frame.
- R3: `ld_n` stays low for the whole transfer, and `sck` is never high while `ld_n` is high.
- R4: Bit k of the byte (bit 0 = LSB) is on `sdo` at the k-th rising `sck` edge of the frame, so the first edge carries bit 0 and the eighth carries bit 7. Within a frame `sdo` changes only when `sck` falls.
- R5: `sck` is high for at least SCK_HIGH_NS and low for at least SCK_LOW_NS, with at least their sum between rising edges.
- R6: `ld_n` falls at least LDS_NS before the first rising `sck`. `sdo` is stable at least DS_NS before and DH_NS after each rising `sck`.
- R7: Each frame has exactly eight rising `sck` edges. `ld_n` rises after the eighth edge and before any further one.
- R8: Between the end of one frame and the start of the next, `ld_n` stays high for at least GAP_NS.
- R9: A `rst_req` pulse gives one `disp_rst_n` low pulse of at least RST_NS, with `ld_n` high and `sck` low throughout. A request made during a frame waits until that frame and its gap have completed, and the frame is sent intact.
- R10: When `rst_req` and `in_valid` are both high while idle, the reset pulse comes first, and the byte is sent after the reset and the following gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| in_valid | input | 1 | Upstream byte valid |
| in_data | input | 8 | Upstream byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| rst_req | input | 1 | One-cycle request for a display reset pulse |
| ld_n | output | 1 | Active-low frame strobe to the display |
| sck | output | 1 | Serial shift clock to the display |
| sdo | output | 1 | Serial data to the display |
| disp_rst_n | output | 1 | Active-low display reset |

## Verification
If the phase counter or the state register is wrong, the `sck` high or low runs shrink or stretch. That shows on the next `sck` edge, within one half-period. If the bit counter is off, `ld_n` rises after seven or nine rising edges and the decoded byte is wrong at the end of that same frame. If the shifter is out of step, a bit is misplaced; this is caught at the end of the frame with patterns such as 01h and 80h. A lost reset request shows up as a missing `disp_rst_n` pulse within one frame plus one gap.

// File: rtl/serdisp_pkg.sv
package serdisp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_HIGH, ST_LOW, ST_GAP, ST_RST
  } st_e;

  // convert a minimum time in ns to whole clock cycles, rounding up
  function automatic int ns2cyc(input int ns, input int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/serdisp_timer.sv
module serdisp_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (load)     cnt <= load_val;
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/serdisp_shifter.sv
module serdisp_shifter #(
  parameter int DW = 8,
  localparam int BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          shift,
  output logic          sout,
  output logic          last
);
  logic [DW-1:0] sr;
  logic [BW-1:0] pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      pos <= '0;
    end else if (load) begin
      sr  <= din;
      pos <= '0;
    end else if (shift) begin
      sr  <= {1'b0, sr[DW-1:1]};
      pos <= pos + 1'b1;
    end
  end

  assign sout = sr[0];
  assign last = (pos == BW'(DW - 1));
endmodule

// File: rtl/serdisp_tx.sv
module serdisp_tx
  import serdisp_pkg::*;
#(
  parameter int CLK_PS      = 5000,
  parameter int SCK_HIGH_NS = 100,
  parameter int SCK_LOW_NS  = 100,
  parameter int LDS_NS      = 50,
  parameter int DS_NS       = 50,
  parameter int DH_NS       = 25,
  parameter int GAP_NS      = 600,
  parameter int RST_NS      = 600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  input  logic       rst_req,
  output logic       ld_n,
  output logic       sck,
  output logic       sdo,
  output logic       disp_rst_n
);
  // data changes at the sck fall, so hold after a rise is the high phase
  localparam int HI_C  = imax(ns2cyc(SCK_HIGH_NS, CLK_PS), ns2cyc(DH_NS, CLK_PS));
  localparam int LO_C  = imax(ns2cyc(SCK_LOW_NS, CLK_PS), ns2cyc(DS_NS, CLK_PS));
  localparam int SU_C  = imax(LO_C, ns2cyc(LDS_NS, CLK_PS));
  localparam int GAP_C = ns2cyc(GAP_NS, CLK_PS);
  localparam int RST_C = ns2cyc(RST_NS, CLK_PS);
  localparam int MAXC  = imax(imax(HI_C, SU_C), imax(GAP_C, RST_C));
  localparam int CW    = $clog2(MAXC + 1);

  st_e           state, nstate;
  logic          rst_pend;
  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  logic          sh_load, sh_shift, sh_last;
  logic          take_rst;

  serdisp_timer #(.W(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  serdisp_shifter #(.DW(8)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .din(in_data), .shift(sh_shift),
    .sout(sdo), .last(sh_last)
  );

  assign take_rst = rst_pend | rst_req;
  assign in_ready = (state == ST_IDLE) && !take_rst;

  always_comb begin
    nstate   = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (take_rst) begin
          nstate = ST_RST;   tmr_load = 1'b1; tmr_val = CW'(RST_C - 1);
        end else if (in_valid) begin
          nstate = ST_SETUP; tmr_load = 1'b1; tmr_val = CW'(SU_C - 1);
          sh_load = 1'b1;
        end
      end
      ST_SETUP, ST_LOW: if (tmr_done) begin
        nstate = ST_HIGH; tmr_load = 1'b1; tmr_val = CW'(HI_C - 1);
      end
      ST_HIGH: if (tmr_done) begin
        tmr_load = 1'b1;
        if (sh_last) begin
          nstate = ST_GAP; tmr_val = CW'(GAP_C - 1);
        end else begin
          nstate = ST_LOW; tmr_val = CW'(LO_C - 1); sh_shift = 1'b1;
        end
      end
      ST_RST: if (tmr_done) begin
        nstate = ST_GAP; tmr_load = 1'b1; tmr_val = CW'(GAP_C - 1);
      end
      ST_GAP: if (tmr_done) nstate = ST_IDLE;
      default: nstate = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rst_pend <= 1'b0;
    end else begin
      state <= nstate;
      if (nstate == ST_RST) rst_pend <= 1'b0;
      else if (rst_req)     rst_pend <= 1'b1;
    end
  end

  assign ld_n       = !(state inside {ST_SETUP, ST_HIGH, ST_LOW});
  assign sck        = (state == ST_HIGH);
  assign disp_rst_n = (state != ST_RST);

  // R3
  sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !ld_n);
  // R7
  load_rise_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ld_n) |-> $past(sck));
  // R4
  data_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_n && $past(!ld_n) && !$stable(sdo)) |-> $fell(sck));
  // R9
  reset_idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(disp_rst_n) |-> ($past(ld_n) && !$past(sck)));
  // R2
  ready_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (ld_n && disp_rst_n && !sck));
  // R9
  one_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!ld_n, !disp_rst_n}));
endmodule

// File: tb/sim_serdisp_tx.sv
module sim_serdisp_tx;
  localparam int CLK_PS = 5000;
  function automatic int cyc(input int ns);
    return (ns * 1000 + CLK_PS - 1) / CLK_PS;
  endfunction
  localparam int HI_MIN  = cyc(100);
  localparam int LO_MIN  = cyc(100);
  localparam int PER_MIN = cyc(200);
  localparam int LDS_MIN = cyc(50);
  localparam int DS_MIN  = cyc(50);
  localparam int DH_MIN  = cyc(25);
  localparam int GAP_MIN = cyc(600);
  localparam int RST_MIN = cyc(600);

  localparam logic [7:0] VEC [0:7] = '{8'h00, 8'hFF, 8'hA5, 8'h5A,
                                       8'h01, 8'h80, 8'h3C, 8'h1F};

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, rst_req = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, ld_n, sck, sdo, disp_rst_n;

  always #2.5 clk = ~clk;

  serdisp_tx u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .rst_req(rst_req), .ld_n(ld_n), .sck(sck),
    .sdo(sdo), .disp_rst_n(disp_rst_n)
  );

  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // receiver model and timing monitor
  logic [7:0] rx_bytes [0:31];
  int rx_n = 0, rst_pulses = 0;
  logic [7:0] rx_sh;
  int bitpos, lo_run, hi_run, since_rise, stab, ldf, gap_run, rst_run;
  bit had_frame, p_sck, p_ld, p_sdo, p_rdy, p_rst, ld_in_rst;

  always @(negedge clk) begin
    if (!rst_n) begin
      bitpos = 0; lo_run = 0; hi_run = 0; since_rise = 1000; stab = 1000;
      ldf = 0; gap_run = 1000; rst_run = 0; had_frame = 0; ld_in_rst = 0;
      p_sck = 0; p_ld = 1; p_sdo = 0; p_rdy = 1; p_rst = 1;
    end else begin
      if (!ld_n && p_ld) begin
        if (had_frame) chk(gap_run >= GAP_MIN, "R8 gap between frames", gap_run, GAP_MIN);
        bitpos = 0;
      end
      if (sck && !p_sck) begin
        chk(!ld_n, "R3 sck high with ld_n high", ld_n, 0);
        chk(lo_run >= LO_MIN, "R5 sck low width", lo_run, LO_MIN);
        chk(stab >= DS_MIN, "R6 data setup", stab, DS_MIN);
        if (bitpos == 0) chk(ldf >= LDS_MIN, "R6 load setup", ldf, LDS_MIN);
        else             chk(since_rise >= PER_MIN, "R5 sck period", since_rise, PER_MIN);
        if (bitpos < 8) rx_sh[bitpos] = sdo;
        bitpos++;
      end
      if (!sck && p_sck) chk(hi_run >= HI_MIN, "R5 sck high width", hi_run, HI_MIN);
      if (sdo != p_sdo && !ld_n && !p_ld && bitpos > 0)
        chk(since_rise >= DH_MIN, "R6 data hold", since_rise, DH_MIN);
      if (ld_n && !p_ld) begin
        chk(bitpos == 8, "R7 rising edges per frame", bitpos, 8);
        rx_bytes[rx_n[4:0]] = rx_sh;
        rx_n++;
        had_frame = 1;
      end
      if (in_ready && !p_rdy && had_frame)
        chk(gap_run >= GAP_MIN, "R2 ready before gap expired", gap_run, GAP_MIN);
      if (!disp_rst_n && p_rst) begin
        ld_in_rst = 0;
        if (had_frame) chk(gap_run >= GAP_MIN, "R9 reset before gap", gap_run, GAP_MIN);
      end
      if (!disp_rst_n && (!ld_n || sck)) ld_in_rst = 1;
      if (disp_rst_n && !p_rst) begin
        chk(rst_run >= RST_MIN, "R9 reset width", rst_run, RST_MIN);
        chk(!ld_in_rst, "R9 lines active during reset", ld_in_rst, 0);
        rst_pulses++;
      end
      // counters for the next sample
      lo_run     = sck ? 0 : lo_run + 1;
      hi_run     = sck ? hi_run + 1 : 0;
      since_rise = (sck && !p_sck) ? 1 : since_rise + 1;
      stab       = (sdo != p_sdo) ? 1 : stab + 1;
      ldf        = (!ld_n && p_ld) ? 1 : ldf + 1;
      gap_run    = ld_n ? gap_run + 1 : 0;
      rst_run    = disp_rst_n ? 0 : rst_run + 1;
      p_sck = sck; p_ld = ld_n; p_sdo = sdo; p_rdy = in_ready; p_rst = disp_rst_n;
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    chk(!in_ready, "R2 ready after accept", in_ready, 0);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (in_ready) break;
    end
  endtask

  int cycles = 0;
  bit timed_out = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !timed_out) begin
      timed_out = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int base, rp;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ld_n == 1 && sck == 0 && disp_rst_n == 1, "R1 outputs in reset",
        {ld_n, sck, disp_rst_n}, 3'b101);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1, "R1 ready after reset", in_ready, 1);
    chk(ld_n == 1 && disp_rst_n == 1, "R1 idle lines", {ld_n, disp_rst_n}, 2'b11);

    // table of bytes: R4 bit order, R3/R5/R6/R7 timing via the monitor
    for (int i = 0; i < 8; i++) begin
      base = rx_n;
      send(VEC[i]);
      wait_idle();
      chk(rx_n == base + 1, "R7 frame count", rx_n, base + 1);
      chk(rx_bytes[base[4:0]] == VEC[i], "R4 decoded byte", rx_bytes[base[4:0]], VEC[i]);
    end

    // R8 back-to-back: valid held, next byte waits for the gap
    base = rx_n;
    send(8'hC3);
    send(8'h96);
    wait_idle();
    chk(rx_n == base + 2, "R8 back-to-back count", rx_n, base + 2);
    chk(rx_bytes[base[4:0]] == 8'hC3 && rx_bytes[(base + 1) & 31] == 8'h96,
        "R8 back-to-back bytes", rx_bytes[(base + 1) & 31], 8'h96);

    // R10 reset wins over a waiting byte
    base = rx_n; rp = rst_pulses;
    @(negedge clk);
    rst_req = 1'b1; in_valid = 1'b1; in_data = 8'h6D;
    @(negedge clk);
    rst_req = 1'b0;
    chk(disp_rst_n == 0 && ld_n == 1, "R10 reset first", {disp_rst_n, ld_n}, 2'b01);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
    wait_idle();
    chk(rst_pulses == rp + 1, "R10 one reset pulse", rst_pulses, rp + 1);
    chk(rx_n == base + 1 && rx_bytes[base[4:0]] == 8'h6D, "R10 byte after reset",
        rx_bytes[base[4:0]], 8'h6D);

    // R9 request during a frame is held until the frame and gap end
    base = rx_n; rp = rst_pulses;
    send(8'hE7);
    while (ld_n) @(negedge clk);
    repeat (30) @(negedge clk);
    rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0;
    chk(disp_rst_n == 1 && ld_n == 0, "R9 frame not cut", {disp_rst_n, ld_n}, 2'b10);
    wait_idle();
    chk(rst_pulses == rp + 1, "R9 deferred reset pulse", rst_pulses, rp + 1);
    chk(rx_n == base + 1 && rx_bytes[base[4:0]] == 8'hE7, "R9 frame intact",
        rx_bytes[base[4:0]], 8'hE7);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule